// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block keeps the two program-counter registers of a processor whose control transfers are delayed by one instruction: the address being fetched (PC) and the address that follows it (NPC). Every time an instruction retires, the pipeline sends a one-cycle strobe together with the instruction's class, a taken flag and a target address. On that strobe the block moves NPC into PC and then loads NPC with the successor address. The successor is either the old NPC plus one instruction width or, for a taken transfer, the target.

A transfer never writes PC directly. Because of this, a transfer placed in the delay slot of another transfer needs no special handling. Exactly one instruction runs at the first target, and fetch then goes on at the second target. A register-indirect jump uses the same path as a branch. The block also returns the address of the retiring instruction so that a jump-and-link can write it to its link register. A redirect to a target that is not instruction-aligned is refused: the block raises a flag and leaves both registers as they were.

Top module: `pc_npc_seq`

## Requirements
- R1: While reset is asserted, and after it is released, fetch_pc_o equals RESET_VEC and npc_o equals RESET_VEC + 4 until the first accepted retire.
- R2: On an accepted retire (retire_i high, misalign_o low), fetch_pc_o takes the value npc_o had before the edge.
- R3: An accepted retire advances npc_o by 4 in three cases: cls_i = 0 (sequential), cls_i = 3 (reserved, handled as sequential), and cls_i = 1 (branch) with taken_i low. In each case target_i is ignored, including its low bits.
- R4: An accepted retire with cls_i = 1 and taken_i high loads npc_o with target_i. fetch_pc_o never takes target_i on the same edge.
- R5: An accepted retire with cls_i = 2 (register jump) loads npc_o with target_i whatever the value of taken_i.
- R6: A transfer retired in the delay slot of another transfer is honoured. From reset at 0x00, a branch to 0x20 followed by a branch to 0x30 yields the (PC, NPC) trace (0x00,0x04), (0x04,0x20), (0x20,0x30), (0x30,0x34), (0x34,0x38).
- R7: When retire_i is low, fetch_pc_o and npc_o hold their values.
- R8: When a retire would redirect (R4 or R5) and target_i[1:0] is not zero, misalign_o is high in that same cycle and fetch_pc_o and npc_o stay unchanged. misalign_o is low in every other cycle.
- R9: link_o always equals fetch_pc_o, the address of the instruction that is retiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One-cycle strobe: an instruction retires |
| cls_i | input | 2 | Class of the retiring instruction: 0 sequential, 1 branch, 2 register jump, 3 reserved |
| taken_i | input | 1 | Branch condition result |
| target_i | input | ADDR_W | Branch target or register jump address |
| fetch_pc_o | output | ADDR_W | Current PC, the fetch address |
| npc_o | output | ADDR_W | Next PC |
| link_o | output | ADDR_W | Return address for jump-and-link: the PC of the retiring instruction |
| misalign_o | output | 1 | Redirect refused because the target is misaligned |

## Verification
A wrong NPC cannot be seen in fetch_pc_o until the following retire, so the bench compares both registers after every clock edge, and a fault appears at npc_o one cycle after the retire that caused it. Delay-slot chains and idle gaps between retires are mixed in on purpose. An error that only corrupts the handoff from NPC into PC therefore shows up at fetch_pc_o on the next strobe rather than being masked by a later redirect. The misalignment flag and the link address are combinational, so they are checked within the retire cycle itself.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    XFER_SEQ = 2'd0,
    XFER_BR  = 2'd1,
    XFER_JMP = 2'd2,
    XFER_RSV = 2'd3
  } xfer_cls_e;
endpackage

// File: rtl/pcseq_redirect.sv
module pcseq_redirect
  import pcseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  xfer_cls_e           cls_i,
  input  logic                taken_i,
  input  logic [ADDR_W-1:0]   target_i,
  output logic                redirect_o,
  output logic                misalign_o
);
  always_comb begin
    unique case (cls_i)
      XFER_BR:  redirect_o = taken_i;
      XFER_JMP: redirect_o = 1'b1;
      default:  redirect_o = 1'b0;
    endcase
  end

  // only a redirect consumes the target; sequential retires ignore its low bits
  assign misalign_o = redirect_o && (target_i[ALIGN_BITS-1:0] != '0);
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_nxt_o,
  output logic [ADDR_W-1:0] npc_nxt_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] seq_addr;
  logic              unused_pc;

  assign seq_addr  = npc_i + STEP_V;
  // PC always follows NPC; a transfer only ever rewrites NPC
  assign pc_nxt_o  = npc_i;
  assign npc_nxt_o = redirect_i ? target_i : seq_addr;
  assign unused_pc = ^pc_i;
endmodule

// File: rtl/pcseq_regs.sv
module pcseq_regs #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter int                STEP      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] pc_d_i,
  input  logic [ADDR_W-1:0] npc_d_i,
  output logic [ADDR_W-1:0] pc_q_o,
  output logic [ADDR_W-1:0] npc_q_o
);
  localparam logic [ADDR_W-1:0] RESET_NPC = RESET_VEC + ADDR_W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q_o  <= RESET_VEC;
      npc_q_o <= RESET_NPC;
    end else if (en_i) begin
      pc_q_o  <= pc_d_i;
      npc_q_o <= npc_d_i;
    end
  end
endmodule

// File: rtl/pc_npc_seq.sv
module pc_npc_seq
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic [1:0]        cls_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              misalign_o
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);

  xfer_cls_e         cls;
  logic              redirect, bad_tgt, upd_en;
  logic [ADDR_W-1:0] pc_q, npc_q, pc_nxt, npc_nxt;

  assign cls = xfer_cls_e'(cls_i);

  pcseq_redirect #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) i_redirect (
    .cls_i      (cls),
    .taken_i    (taken_i),
    .target_i   (target_i),
    .redirect_o (redirect),
    .misalign_o (bad_tgt)
  );

  pcseq_next #(.ADDR_W(ADDR_W), .STEP(INSN_BYTES)) i_next (
    .pc_i       (pc_q),
    .npc_i      (npc_q),
    .redirect_i (redirect),
    .target_i   (target_i),
    .pc_nxt_o   (pc_nxt),
    .npc_nxt_o  (npc_nxt)
  );

  assign upd_en = retire_i && !bad_tgt;

  pcseq_regs #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC), .STEP(INSN_BYTES)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (upd_en),
    .pc_d_i  (pc_nxt),
    .npc_d_i (npc_nxt),
    .pc_q_o  (pc_q),
    .npc_q_o (npc_q)
  );

  assign fetch_pc_o = pc_q;
  assign npc_o      = npc_q;
  assign link_o     = pc_q;
  assign misalign_o = retire_i && bad_tgt;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic [1:0]        cls_i,
  input logic              taken_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic [ADDR_W-1:0] npc_o,
  input logic [ADDR_W-1:0] link_o,
  input logic              misalign_o
);
  logic redir_c, seq_c;
  assign redir_c = (cls_i == 2'd2) || (cls_i == 2'd1 && taken_i);
  assign seq_c   = !redir_c;

  assert_pc_follows_npc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !misalign_o |=> fetch_pc_o == $past(npc_o));

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && seq_c |=> npc_o == $past(npc_o) + ADDR_W'(4));

  assert_redirect_npc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && redir_c && !misalign_o |=> npc_o == $past(target_i));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(fetch_pc_o) && $stable(npc_o));

  assert_misalign_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> $stable(fetch_pc_o) && $stable(npc_o));

  assert_misalign_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> retire_i && redir_c && target_i[1:0] != 2'b00);

  assert_link_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o == fetch_pc_o);
endmodule

bind pc_npc_seq pcseq_checker #(.ADDR_W(ADDR_W)) i_pcseq_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .retire_i   (retire_i),
  .cls_i      (cls_i),
  .taken_i    (taken_i),
  .target_i   (target_i),
  .fetch_pc_o (fetch_pc_o),
  .npc_o      (npc_o),
  .link_o     (link_o),
  .misalign_o (misalign_o)
);

// File: tb/test_pc_npc_seq.sv
module test_pc_npc_seq;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          retire_i = 1'b0;
  logic [1:0]    cls_i = 2'd0;
  logic          taken_i = 1'b0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] fetch_pc_o, npc_o, link_o;
  logic          misalign_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_pc, m_npc;

  always #2.5 clk_i = ~clk_i;

  pc_npc_seq #(.ADDR_W(AW), .INSN_BYTES(4), .RESET_VEC('0)) i_pc_npc_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i), .cls_i(cls_i),
    .taken_i(taken_i), .target_i(target_i), .fetch_pc_o(fetch_pc_o),
    .npc_o(npc_o), .link_o(link_o), .misalign_o(misalign_o)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cmp_regs(input string req);
    chk(fetch_pc_o == m_pc, {req, " pc"}, fetch_pc_o, m_pc);
    chk(npc_o == m_npc, {req, " npc"}, npc_o, m_npc);
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model at edge
  task automatic step(input bit ret, input logic [1:0] c, input bit tk,
                      input logic [AW-1:0] tgt, input string req);
    bit redir, bad;
    @(negedge clk_i);
    retire_i = ret; cls_i = c; taken_i = tk; target_i = tgt;
    redir = (c == 2'd2) || (c == 2'd1 && tk);
    bad   = redir && (tgt[1:0] != 2'b00);
    #1;
    chk(misalign_o == (ret && bad), {req, " R8 misalign"}, AW'(misalign_o), AW'(ret && bad));
    chk(link_o == m_pc, {req, " R9 link"}, link_o, m_pc);
    @(posedge clk_i);
    if (ret && !bad) begin
      m_pc  = m_npc;
      m_npc = redir ? tgt : m_npc + 32'd4;
    end
    #1;
    cmp_regs(req);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h0; m_npc = 32'h4;
    repeat (3) @(posedge clk_i);
    #1 cmp_regs("R1 in reset");
    @(negedge clk_i) rst_ni = 1'b1;
    #1 cmp_regs("R1 after release");

    // R6: delay-slot chain from reset vector 0
    step(1, 2'd1, 1, 32'h20, "R6");
    chk(fetch_pc_o == 32'h04 && npc_o == 32'h20, "R6 trace2", npc_o, 32'h20);
    step(1, 2'd1, 1, 32'h30, "R6");
    chk(fetch_pc_o == 32'h20 && npc_o == 32'h30, "R6 trace3", fetch_pc_o, 32'h20);
    step(1, 2'd0, 0, 32'h0, "R6");
    chk(fetch_pc_o == 32'h30 && npc_o == 32'h34, "R6 trace4", fetch_pc_o, 32'h30);
    step(1, 2'd0, 0, 32'h0, "R6");
    chk(fetch_pc_o == 32'h34 && npc_o == 32'h38, "R6 trace5", fetch_pc_o, 32'h34);

    // R7: idle cycles, inputs wiggle
    step(0, 2'd2, 1, 32'h400, "R7 idle jump");
    step(0, 2'd1, 1, 32'h800, "R7 idle branch");
    // R3: sequential with junk target, not-taken branch, reserved code
    step(1, 2'd0, 1, 32'h123, "R3 seq junk tgt");
    step(1, 2'd1, 0, 32'h1000, "R3 not-taken");
    step(1, 2'd3, 1, 32'h2000, "R3 reserved");
    // R4: taken branch, PC not target on same edge
    step(1, 2'd1, 1, 32'h100, "R4 taken");
    chk(fetch_pc_o != 32'h100, "R4 pc not target", fetch_pc_o, m_pc);
    // R5: jump ignores taken flag
    step(1, 2'd2, 0, 32'h200, "R5 jump");
    // jump in delay slot of jump
    step(1, 2'd2, 1, 32'h300, "R6 jump pair");
    step(1, 2'd0, 0, 32'h0, "R6 jump pair");
    // R8: misaligned redirects refused
    step(1, 2'd2, 0, 32'h402, "R8 jump");
    step(1, 2'd1, 1, 32'h501, "R8 branch");
    step(1, 2'd1, 0, 32'h503, "R8 not-taken ok");

    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] t;
      t = $urandom & 32'hFFFF;
      if (($urandom % 4) != 0) t[1:0] = 2'b00;
      step(($urandom % 5) != 0, 2'($urandom), 1'($urandom), t, "R2 mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule